// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Dual Compare and Interrupt Requests

This block is an 8-bit up-counter with two compare registers, a control register, an interrupt flag register and an interrupt mask register. A simple synchronous register port gives write access to all of them and combinational read-back. A 2-bit mode code selects how the counter moves on each tick:
- Normal, phase-correct PWM and fast PWM wrap from the top value to zero.
- CTC (clear on compare A) reloads zero when the fresh count equals compare register A.

Overflow and the two compare matches are each judged on the count produced by the tick. Each one sets a sticky flag. Software clears a flag by writing a 1 to its bit.

A flag that is also enabled in the mask, while the global interrupt enable input is high, raises the request output. An identifier output names the source being offered, in fixed priority order. When the host acknowledges, the flag of that source is cleared and the counter is left untouched. A clock-select field either runs the counter at the full clock rate or stops it.

Top module: `tmr8_unit`

## Requirements
- R1: After synchronous reset every register reads 0 and the request output is low.
- R2: Register addresses are 0 count, 1 compare A, 2 compare B, 3 control, 4 flags, 5 mask. Control reads back as {0, select[2:0], 00, mode[1:0]}, with select in bits 6:4 and mode in bits 1:0. Flags and mask occupy bits 2:0. Addresses 6 and 7 read 0.
- R3: A select value of 1 adds one to the count on every clock edge. Every other select value, including 0, holds the count. A change of select takes effect from the edge after it is written.
- R4: In every mode, a tick from 0xFF leaves the count at 0 and sets flag bit 0 (overflow).
- R5: A tick whose resulting count equals compare A sets flag bit 1.
- R6: A tick whose resulting count equals compare B sets flag bit 2.
- R7: With mode 2 (CTC), a tick whose result equals compare A loads 0 into the count. Mode codes are 0 normal, 1 phase-correct PWM, 2 CTC and 3 fast PWM.
- R8: A write to the count register wins over a tick in the same cycle. That cycle produces no overflow or compare event.
- R9: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A hardware set in the same cycle wins over a clear.
- R10: The request is high exactly when the global enable is high and some flag bit is set together with its mask bit (bit 0 overflow, bit 1 compare A, bit 2 compare B).
- R11: When several sources are pending, the identifier names compare A (1) first, then compare B (2), then overflow (0).
- R12: An acknowledge while the request is high clears the flag named by the identifier and leaves the count and all other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| gie | input | 1 | Global interrupt enable |
| ack | input | 1 | Host acknowledge of the offered request |
| irq | output | 1 | Interrupt request |
| irq_id | output | 2 | Flag bit index of the source offered |

## Verification
The bench builds the block with its default parameters: an 8-bit count and a 3-bit address. With 8 bits, the counter wraps every 256 ticks, so a few thousand random cycles cross the top value and each compare value many times, with writes, acknowledges and flag clears landing on those edges. The 3-bit address makes the two unmapped addresses reachable, so their zero read-back is exercised. Directed sequences pin the exact cycle of each wrap, match, CTC reload and acknowledge.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int TMR_DW = 8;
    localparam int TMR_AW = 3;
    localparam int N_SRC  = 3;

    // flag / mask bit positions
    localparam int FLG_OVF = 0;
    localparam int FLG_CMA = 1;
    localparam int FLG_CMB = 2;

    // register addresses
    localparam logic [TMR_AW-1:0] RA_CNT  = 3'd0;
    localparam logic [TMR_AW-1:0] RA_CMPA = 3'd1;
    localparam logic [TMR_AW-1:0] RA_CMPB = 3'd2;
    localparam logic [TMR_AW-1:0] RA_CTRL = 3'd3;
    localparam logic [TMR_AW-1:0] RA_FLAG = 3'd4;
    localparam logic [TMR_AW-1:0] RA_MASK = 3'd5;

    localparam logic [2:0] CS_RUN = 3'd1;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_PC_PWM   = 2'd1,
        MODE_CTC      = 2'd2,
        MODE_FAST_PWM = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic [2:0] clk_sel;
        tmr_mode_e  mode;
    } tmr_ctrl_t;

    // event vector laid out on the flag bit positions
    typedef struct packed {
        logic cmb;
        logic cma;
        logic ovf;
    } tmr_evt_t;

    function automatic logic [7:0] pack_ctrl(input tmr_ctrl_t c);
        return {1'b0, c.clk_sel, 2'b00, c.mode};
    endfunction

    function automatic tmr_ctrl_t unpack_ctrl(input logic [7:0] d);
        tmr_ctrl_t c;
        c.clk_sel = d[6:4];
        c.mode    = tmr_mode_e'(d[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/tmr8_cfg_regs.sv
module tmr8_cfg_regs
    import tmr8_pkg::*;
#(
    parameter int DW = TMR_DW,
    parameter int AW = TMR_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] cmp_a,
    output logic [DW-1:0] cmp_b,
    output tmr_ctrl_t     ctrl,
    output logic [N_SRC-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_a <= '0;
            cmp_b <= '0;
            ctrl  <= '0;
            mask  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_CMPA: cmp_a <= wr_data;
                RA_CMPB: cmp_b <= wr_data;
                RA_CTRL: ctrl  <= unpack_ctrl(wr_data[7:0]);
                RA_MASK: mask  <= wr_data[N_SRC-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tmr8_count_core.sv
module tmr8_count_core
    import tmr8_pkg::*;
#(
    parameter int DW = TMR_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_ctrl_t     ctrl,
    input  logic [DW-1:0] cmp_a,
    input  logic [DW-1:0] cmp_b,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] cnt,
    output tmr_evt_t      evt
);

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] cnt_inc;
    logic          tick;
    logic          ctc_clr;

    assign tick    = (ctrl.clk_sel == CS_RUN) && !ld_en;
    assign cnt_inc = cnt_q + DW'(1);

    always_comb begin
        evt.ovf = tick && (&cnt_q);
        evt.cma = tick && (cnt_inc == cmp_a);
        evt.cmb = tick && (cnt_inc == cmp_b);
        ctc_clr = (ctrl.mode == MODE_CTC) && evt.cma;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ld_en)
            cnt_q <= ld_val;
        else if (tick)
            cnt_q <= ctc_clr ? '0 : cnt_inc;
    end

    assign cnt = cnt_q;

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && ctrl.clk_sel != CS_RUN) |=> $stable(cnt_q)); // R3

    AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && ctrl.clk_sel == CS_RUN && ctrl.mode == MODE_CTC &&
         (cnt_q + DW'(1)) == cmp_a) |=> (cnt_q == '0)); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (cnt_q == $past(ld_val))); // R8

endmodule

// File: rtl/tmr8_irq_ctl.sv
module tmr8_irq_ctl
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tmr_evt_t         evt,
    input  logic             w1c_en,
    input  logic [N_SRC-1:0] w1c_bits,
    input  logic [N_SRC-1:0] mask,
    input  logic             gie,
    input  logic             ack,
    output logic [N_SRC-1:0] flags,
    output logic             irq,
    output logic [1:0]       irq_id
);

    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] flags_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] grant;
    logic [N_SRC-1:0] ack_clr;

    assign set_vec = evt;
    assign pend    = gie ? (flags_q & mask) : '0;

    // fixed priority: compare A, compare B, overflow
    always_comb begin
        grant  = '0;
        irq_id = 2'(FLG_OVF);
        if (pend[FLG_CMA]) begin
            grant[FLG_CMA] = 1'b1;
            irq_id = 2'(FLG_CMA);
        end else if (pend[FLG_CMB]) begin
            grant[FLG_CMB] = 1'b1;
            irq_id = 2'(FLG_CMB);
        end else if (pend[FLG_OVF]) begin
            grant[FLG_OVF] = 1'b1;
        end
    end

    assign irq     = |pend;
    assign ack_clr = ack ? grant : '0;

    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[g] <= 1'b0;
            else if (set_vec[g])
                flags_q[g] <= 1'b1;
            else if ((w1c_en && w1c_bits[g]) || ack_clr[g])
                flags_q[g] <= 1'b0;
        end
    end

    assign flags = flags_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R11

    AST_CMA_FIRST: assert property (@(posedge clk) disable iff (rst)
        (irq && flags_q[FLG_CMA] && mask[FLG_CMA]) |-> (irq_id == 2'(FLG_CMA))); // R11

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        evt.ovf |=> flags_q[FLG_OVF]); // R4

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ack && irq && !set_vec[irq_id]) |=> !flags_q[$past(irq_id)]); // R12

endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
    import tmr8_pkg::*;
#(
    parameter int CNT_W  = TMR_DW,
    parameter int ADDR_W = TMR_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              gie,
    input  logic              ack,
    output logic              irq,
    output logic [1:0]        irq_id
);

    logic [CNT_W-1:0] cmp_a;
    logic [CNT_W-1:0] cmp_b;
    logic [CNT_W-1:0] cnt;
    tmr_ctrl_t        ctrl;
    logic [N_SRC-1:0] mask;
    logic [N_SRC-1:0] flags;
    tmr_evt_t         evt;
    logic             ld_en;
    logic             w1c_en;

    assign ld_en  = wr_en && (addr == RA_CNT);
    assign w1c_en = wr_en && (addr == RA_FLAG);

    tmr8_cfg_regs #(.DW(CNT_W), .AW(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (wr_data),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .ctrl    (ctrl),
        .mask    (mask)
    );

    tmr8_count_core #(.DW(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .ld_en  (ld_en),
        .ld_val (wr_data),
        .cnt    (cnt),
        .evt    (evt)
    );

    tmr8_irq_ctl u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .w1c_en   (w1c_en),
        .w1c_bits (wr_data[N_SRC-1:0]),
        .mask     (mask),
        .gie      (gie),
        .ack      (ack),
        .flags    (flags),
        .irq      (irq),
        .irq_id   (irq_id)
    );

    always_comb begin
        case (addr)
            RA_CNT:  rd_data = cnt;
            RA_CMPA: rd_data = cmp_a;
            RA_CMPB: rd_data = cmp_b;
            RA_CTRL: rd_data = CNT_W'(pack_ctrl(ctrl));
            RA_FLAG: rd_data = CNT_W'(flags);
            RA_MASK: rd_data = CNT_W'(mask);
            default: rd_data = '0;
        endcase
    end

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        irq |-> gie); // R10

endmodule

// File: tb/test_tmr8_unit.sv
module test_tmr8_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       gie;
    logic       ack;
    logic       irq;
    logic [1:0] irq_id;

    always #4 clk = ~clk;   // 125 MHz

    tmr8_unit i_tmr8_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .gie(gie), .ack(ack), .irq(irq), .irq_id(irq_id)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_cnt, m_a, m_b;
    logic [1:0] m_mode;
    logic [2:0] m_cs, m_flags, m_mask;
    logic [7:0] last_rd;
    logic       last_irq;
    logic [1:0] last_id;
    logic       g_cur;

    task automatic chk(input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
        end
    endtask

    function automatic logic [2:0] m_pend(input logic g);
        return g ? (m_flags & m_mask) : 3'b000;
    endfunction

    function automatic logic m_irq(input logic g);
        return |m_pend(g);
    endfunction

    function automatic logic [1:0] m_id(input logic g);
        logic [2:0] p;
        p = m_pend(g);
        if (p[1]) return 2'd1;
        if (p[2]) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [7:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt;
            3'd1: return m_a;
            3'd2: return m_b;
            3'd3: return {1'b0, m_cs, 2'b00, m_mode};
            3'd4: return {5'b0, m_flags};
            3'd5: return {5'b0, m_mask};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset();
        m_cnt = 0; m_a = 0; m_b = 0; m_mode = 0; m_cs = 0; m_flags = 0; m_mask = 0;
    endtask

    task automatic m_update(input logic we, input logic [2:0] a, input logic [7:0] d,
                            input logic ak, input logic g);
        logic [2:0] set_b;
        logic [2:0] clr_b;
        logic [7:0] nx;
        set_b = 3'b000;
        clr_b = 3'b000;
        if (ak && m_irq(g)) clr_b[m_id(g)] = 1'b1;
        if (we && a == 3'd4) clr_b = clr_b | d[2:0];
        if (we && a == 3'd0) begin
            m_cnt = d;
        end else if (m_cs == 3'd1) begin
            nx = m_cnt + 8'd1;
            if (m_cnt == 8'hFF) set_b[0] = 1'b1;
            if (nx == m_a) set_b[1] = 1'b1;
            if (nx == m_b) set_b[2] = 1'b1;
            m_cnt = (m_mode == 2'd2 && nx == m_a) ? 8'h00 : nx;
        end
        m_flags = (m_flags & ~clr_b) | set_b;
        if (we) begin
            case (a)
                3'd1: m_a = d;
                3'd2: m_b = d;
                3'd3: begin m_cs = d[6:4]; m_mode = d[1:0]; end
                3'd5: m_mask = d[2:0];
                default: ;
            endcase
        end
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                        input logic ak, input logic g, input string tag);
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; ack = ak; gie = g;
        #1;
        last_rd = rd_data; last_irq = irq; last_id = irq_id;
        chk(tag, "rd_data", rd_data, m_rd(a));
        chk(tag, "irq", {7'b0, irq}, {7'b0, m_irq(g)});
        if (m_irq(g)) chk(tag, "irq_id", {6'b0, irq_id}, {6'b0, m_id(g)});
        @(posedge clk);
        #1;
        m_update(we, a, d, ak, g);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, g_cur, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd0, 8'h00, 1'b0, g_cur, tag);
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        step(1'b0, a, 8'h00, 1'b0, g_cur, tag);
        chk(tag, "read value", last_rd, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; wr_en = 0; addr = 0; wr_data = 0; ack = 0; gie = 0; g_cur = 0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 8; i++) rd(3'(i), 8'h00, "R1");
        chk("R1", "irq after reset", {7'b0, last_irq}, 8'h00);

        // R2: register read-back and unmapped addresses
        wr(3'd1, 8'h5A, "R2");
        wr(3'd2, 8'hA5, "R2");
        wr(3'd3, 8'h73, "R2");
        wr(3'd5, 8'h06, "R2");
        rd(3'd1, 8'h5A, "R2");
        rd(3'd2, 8'hA5, "R2");
        rd(3'd3, 8'h73, "R2");
        rd(3'd5, 8'h06, "R2");
        rd(3'd6, 8'h00, "R2");
        rd(3'd7, 8'h00, "R2");
        wr(3'd5, 8'h00, "R2");

        // R3: clock select stop / run
        wr(3'd3, 8'h00, "R3");
        wr(3'd0, 8'h33, "R3");
        idle("R3"); idle("R3");
        rd(3'd0, 8'h33, "R3");
        wr(3'd3, 8'h20, "R3");
        idle("R3");
        rd(3'd0, 8'h33, "R3");
        wr(3'd3, 8'h10, "R3");
        rd(3'd0, 8'h33, "R3");
        rd(3'd0, 8'h34, "R3");

        // R5: compare A on incremented count
        wr(3'd3, 8'h00, "R5"); wr(3'd0, 8'h10, "R5"); wr(3'd1, 8'h11, "R5");
        wr(3'd2, 8'h40, "R5"); wr(3'd4, 8'h07, "R5"); wr(3'd3, 8'h10, "R5");
        idle("R5");
        rd(3'd4, 8'h02, "R5");

        // R6: compare B
        wr(3'd3, 8'h00, "R6"); wr(3'd0, 8'h10, "R6"); wr(3'd1, 8'h90, "R6");
        wr(3'd2, 8'h11, "R6"); wr(3'd4, 8'h07, "R6"); wr(3'd3, 8'h10, "R6");
        idle("R6");
        rd(3'd4, 8'h04, "R6");

        // R7: CTC reload on compare A
        wr(3'd3, 8'h00, "R7"); wr(3'd0, 8'h10, "R7"); wr(3'd1, 8'h11, "R7");
        wr(3'd2, 8'h40, "R7"); wr(3'd4, 8'h07, "R7"); wr(3'd3, 8'h12, "R7");
        idle("R7");
        rd(3'd0, 8'h00, "R7");
        rd(3'd4, 8'h02, "R7");

        // R9: write-one-to-clear
        wr(3'd3, 8'h02, "R9");
        wr(3'd4, 8'h00, "R9");
        rd(3'd4, 8'h02, "R9");
        wr(3'd4, 8'h02, "R9");
        rd(3'd4, 8'h00, "R9");

        // R4: overflow wrap in normal, phase-correct and fast modes
        for (int md = 0; md < 4; md++) begin
            if (md == 2) continue;
            wr(3'd3, 8'h00, "R4"); wr(3'd4, 8'h07, "R4"); wr(3'd0, 8'hFF, "R4");
            wr(3'd3, 8'(8'h10 | md), "R4");
            idle("R4");
            rd(3'd0, 8'h00, "R4");
            rd(3'd4, 8'h01, "R4");
        end

        // R8: counter write wins over tick
        wr(3'd0, 8'h50, "R8");
        rd(3'd0, 8'h50, "R8");

        // R10 / R11 / R12: requests, priority, acknowledge
        wr(3'd3, 8'h00, "R10"); wr(3'd5, 8'h00, "R10"); wr(3'd0, 8'hFD, "R10");
        wr(3'd1, 8'hFF, "R10"); wr(3'd2, 8'hFF, "R10"); wr(3'd4, 8'h07, "R10");
        wr(3'd3, 8'h10, "R10");
        idle("R10"); idle("R10"); idle("R10");
        wr(3'd3, 8'h00, "R10");
        rd(3'd4, 8'h07, "R10");
        g_cur = 1'b1;
        idle("R10");
        chk("R10", "irq with mask clear", {7'b0, last_irq}, 8'h00);
        wr(3'd5, 8'h07, "R10");
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R10");
        chk("R10", "irq with gie low", {7'b0, last_irq}, 8'h00);
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R11");
        chk("R11", "irq all pending", {7'b0, last_irq}, 8'h01);
        chk("R11", "id compare A first", {6'b0, last_id}, 8'h01);
        step(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, "R12");
        step(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, "R12");
        chk("R11", "id compare B second", {6'b0, last_id}, 8'h02);
        step(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, "R12");
        chk("R11", "id overflow last", {6'b0, last_id}, 8'h00);
        step(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R12");
        chk("R12", "irq after all acks", {7'b0, last_irq}, 8'h00);
        rd(3'd0, 8'h01, "R12");

        // constrained random run against the reference model
        for (int n = 0; n < 4000; n++) begin
            logic       we_r, ak_r, g_r;
            logic [2:0] a_r;
            logic [7:0] d_r;
            we_r = ($urandom_range(0, 4) == 0);
            a_r  = 3'($urandom_range(0, 7));
            d_r  = 8'($urandom_range(0, 255));
            if (we_r && a_r == 3'd3 && $urandom_range(0, 7) != 0)
                d_r[6:4] = 3'd1;
            ak_r = ($urandom_range(0, 2) == 0);
            g_r  = ($urandom_range(0, 3) != 0);
            step(we_r, a_r, d_r, ak_r, g_r, "random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule